// File: doc/BRIEF.md
# Two-Plane Programmable Logic Array Core

This block evaluates a sum-of-products logic function whose structure is set by configuration bits. Each of 39 array inputs is offered to the product-term plane in true and inverted form, giving 78 literal columns. Each of 75 product terms is the AND of the literals its row selects. The first 64 product terms feed a second programmable plane that forms 36 sum terms. The remaining product terms come out directly: one drives a global register reset and ten drive output enables. Sum terms are grouped as 18 data terms and 18 enable/clock terms, one of each per downstream cell. The cells and the pins are outside this block.

Configuration is written one row at a time through a serial port. Bits are shifted into a staging register, then a load strobe copies it to the row chosen by a plane code and a row number. A read strobe copies a row back into the staging register so it can be shifted out. A one-way protection bit blanks readback of the product-term plane. Only an erase, or a reset, clears it. A 72-bit user signature row stays readable at all times. The logic outputs are combinational in the array inputs and the stored configuration.

Top module: `pla_core`

## Requirements
- R1: Literal column 2*i carries array input i and column 2*i+1 carries its inverse. A product term is the AND of every literal whose bit is set in that term's row.
- R2: A product term with no literal selected evaluates to 1. A term that selects both columns of one input evaluates to 0.
- R3: Product rows 0 to 63 feed the sum plane. Row 64 drives `pt_reset`, and rows 65 to 74 drive `pt_oe[0]` to `pt_oe[9]` in order.
- R4: Sum term s is the OR of the product terms p (0 to 63) whose bit p is set in sum row s. Any count from 1 to 64 may be joined, and a row with none set gives 0. Sums 0 to 17 appear on `sum_d` and sums 18 to 35 appear on `sum_e`.
- R5: On a shift cycle the staging register moves one place toward bit 0, `cfg_sdi` enters at bit 77, and `cfg_sdo` always shows bit 0. After 78 shifts, the first bit sent sits at bit 0.
- R6: A load writes the staging register into the selected row. Plane code 0 selects the product plane (78 bits), code 1 the sum plane (low 64 bits) and code 2 the signature (low 72 bits). The load has no effect when the row is out of range (74 is the last product row and 35 the last sum row) or when the code is 3.
- R7: A read copies the selected row, zero-extended, into the staging register. An out-of-range row or plane code 3 reads as all zeros.
- R8: A lock strobe sets protection. While protection is set, product-plane reads return all zeros, while sum-plane and signature reads still return their contents.
- R9: Only erase or reset clears protection. Erase also clears every configuration row, the signature and the staging register.
- R10: After reset every product term is 1, every sum term is 0, `cfg_sdo` is 0 and protection is clear.
- R11: When strobes coincide, only the highest-priority one acts, in the order erase, lock, load, read, shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst_n | input | 1 | Synchronous active-low reset |
| array_in | input | 39 | Array inputs |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_shift | input | 1 | Shift the staging register one place |
| cfg_load | input | 1 | Write the staging register to the selected row |
| cfg_read | input | 1 | Copy the selected row into the staging register |
| cfg_lock | input | 1 | Set the read protection bit |
| cfg_erase | input | 1 | Clear all configuration and protection |
| cfg_plane | input | 2 | Plane code: 0 product, 1 sum, 2 signature, 3 none |
| cfg_row | input | 7 | Row number within the plane |
| sum_d | output | 18 | Data sum terms (sums 0..17) |
| sum_e | output | 18 | Enable/clock sum terms (sums 18..35) |
| pt_reset | output | 1 | Global reset product term |
| pt_oe | output | 10 | Output-enable product terms |
| cfg_sdo | output | 1 | Serial configuration data out |

## Verification
The bench programs a product term that selects both columns of one input and checks that it stays 0 for every input pattern. A design that used a single literal per input would let that term follow the input. It leaves a product row empty and a sum row empty, and fills a sum row with all 64 terms. A wrong default or a truncated OR would show up on those outputs. It reads out-of-range rows, plane code 3 and a locked product plane, all of which must return zeros, and it confirms that the sum plane and signature are still readable under lock. It also drives coinciding strobes, where a wrong priority would either change the stored data or leave protection set.

// File: rtl/pla_pkg.sv
// Package for the logic array core: the plane selector encoding and a helper.
package pla_pkg;

    // Plane selector codes used by the configuration port.
    typedef enum logic [1:0] {
        PL_PROD = 2'd0,
        PL_SUM  = 2'd1,
        PL_SIG  = 2'd2,
        PL_NONE = 2'd3
    } plane_e;

    // Larger of two integers, for sizing derived widths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
// Configuration store for the logic array core.
// Holds the product plane rows, the sum plane rows, the user signature, the
// protection bit and a serial staging register. Assumes one strobe acts per
// cycle, chosen by the priority erase > lock > load > read > shift. Reset
// clears all state, the same as an erase.
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int COL_N = 78,
    parameter int PT_N  = 75,
    parameter int PT_OR = 64,
    parameter int SUM_N = 36,
    parameter int SIG_W = 72,
    parameter int SH_W  = 78,
    parameter int ROW_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sdi,
    input  logic                         shift_en,
    input  logic                         load_en,
    input  logic                         read_en,
    input  logic                         lock_en,
    input  logic                         erase_en,
    input  logic [1:0]                   plane,
    input  logic [ROW_W-1:0]             row,
    output logic [PT_N-1:0][COL_N-1:0]   prod_cfg,
    output logic [SUM_N-1:0][PT_OR-1:0]  sum_cfg,
    output logic                         sdo
);

    localparam int PI_W = $clog2(PT_N);
    localparam int SI_W = $clog2(SUM_N);

    logic [PT_N-1:0][COL_N-1:0]  prod_q;
    logic [SUM_N-1:0][PT_OR-1:0] sum_q;
    logic [SIG_W-1:0]            sig_q;
    logic                        prot_q;
    logic [SH_W-1:0]             sh_q;
    logic [SH_W-1:0]             rd_val;
    logic                        prod_ok;
    logic                        sum_ok;
    plane_e                      pl;

    assign pl      = plane_e'(plane);
    assign prod_ok = int'(row) < PT_N;
    assign sum_ok  = int'(row) < SUM_N;

    // Select the row image returned by a read, blanked where not permitted.
    always_comb begin
        rd_val = '0;
        case (pl)
            PL_PROD: if (prod_ok && !prot_q) rd_val[COL_N-1:0] = prod_q[row[PI_W-1:0]];
            PL_SUM:  if (sum_ok) rd_val[PT_OR-1:0] = sum_q[row[SI_W-1:0]];
            PL_SIG:  rd_val[SIG_W-1:0] = sig_q;
            default: rd_val = '0;
        endcase
    end

    // Apply the configuration strobes in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            prod_q <= '0;
            sum_q  <= '0;
            sig_q  <= '0;
            prot_q <= 1'b0;
            sh_q   <= '0;
        end else if (lock_en) begin
            prot_q <= 1'b1;
        end else if (load_en) begin
            case (pl)
                PL_PROD: if (prod_ok) prod_q[row[PI_W-1:0]] <= sh_q[COL_N-1:0];
                PL_SUM:  if (sum_ok) sum_q[row[SI_W-1:0]] <= sh_q[PT_OR-1:0];
                PL_SIG:  sig_q <= sh_q[SIG_W-1:0];
                default: ;
            endcase
        end else if (read_en) begin
            sh_q <= rd_val;
        end else if (shift_en) begin
            sh_q <= {sdi, sh_q[SH_W-1:1]};
        end
    end

    assign prod_cfg = prod_q;
    assign sum_cfg  = sum_q;
    assign sdo      = sh_q[0];

    // A locked product-plane read must leave only zeros in the staging register.
    assert_locked_read_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en && !load_en && !lock_en && !erase_en && pl == PL_PROD && prot_q)
        |=> (sh_q == '0));

    // A lock without erase leaves protection set.
    assert_lock_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && !erase_en) |=> prot_q);

    // Protection only falls after an erase or a reset.
    assert_prot_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> ($past(erase_en) || !$past(rst_n)));

    // Erase leaves protection clear and the staging register empty.
    assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (!prot_q && sh_q == '0));

    // A plain shift moves every bit one place toward bit 0.
    assert_shift_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !read_en && !load_en && !lock_en && !erase_en)
        |=> (sh_q[SH_W-2:0] == $past(sh_q[SH_W-1:1])));

endmodule

// File: rtl/pla_prod_plane.sv
// Product plane: builds true/inverted literals from the array inputs and
// forms each product term as the AND of the literals its row selects.
// Assumes column 2*i is input i and column 2*i+1 its inverse. The clock and
// reset serve only the checks.
module pla_prod_plane #(
    parameter int IN_N = 39,
    parameter int PT_N = 75
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IN_N-1:0]               in_vec,
    input  logic [PT_N-1:0][2*IN_N-1:0]   cfg,
    output logic [PT_N-1:0]               pt
);

    localparam int COL_N = 2 * IN_N;

    logic [COL_N-1:0] lit;

    // Literal columns, one true and one inverted per input.
    for (genvar i = 0; i < IN_N; i++) begin : g_lit
        assign lit[2*i]   = in_vec[i];
        assign lit[2*i+1] = ~in_vec[i];
    end

    // Each term is true when every selected literal is true.
    for (genvar p = 0; p < PT_N; p++) begin : g_pt
        assign pt[p] = &(~cfg[p] | lit);

        // An empty row must yield a true product term.
        assert_empty_term_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p] == '0) |-> pt[p]);
    end

endmodule

// File: rtl/pla_sum_plane.sv
// Sum plane: each sum term is the OR of the product terms its row selects.
// Assumes bit p of a sum row connects product term p.
module pla_sum_plane #(
    parameter int PT_OR = 64,
    parameter int SUM_N = 36
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PT_OR-1:0]             pt,
    input  logic [SUM_N-1:0][PT_OR-1:0]  cfg,
    output logic [SUM_N-1:0]             sum
);

    for (genvar s = 0; s < SUM_N; s++) begin : g_sum
        // Join the selected product terms.
        assign sum[s] = |(cfg[s] & pt);

        // An unconnected sum term stays low.
        assert_empty_sum_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[s] == '0) |-> !sum[s]);
    end

endmodule

// File: rtl/pla_core.sv
// Top of the two-plane programmable logic array core.
// Connects the configuration store to the product and sum planes. It splits
// the product terms into sum-plane feeds, the reset term and the enable terms,
// and splits the sums into data and enable/clock groups. Logic outputs are
// combinational; configuration changes take effect after the clock edge.
module pla_core
    import pla_pkg::*;
#(
    parameter int IN_N   = 39,
    parameter int PT_OR  = 64,
    parameter int OE_N   = 10,
    parameter int CELL_N = 18,
    parameter int SIG_W  = 72,
    parameter int ROW_W  = $clog2(imax(PT_OR + 1 + OE_N, 2 * CELL_N))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_N-1:0]   array_in,
    input  logic              cfg_sdi,
    input  logic              cfg_shift,
    input  logic              cfg_load,
    input  logic              cfg_read,
    input  logic              cfg_lock,
    input  logic              cfg_erase,
    input  logic [1:0]        cfg_plane,
    input  logic [ROW_W-1:0]  cfg_row,
    output logic [CELL_N-1:0] sum_d,
    output logic [CELL_N-1:0] sum_e,
    output logic              pt_reset,
    output logic [OE_N-1:0]   pt_oe,
    output logic              cfg_sdo
);

    localparam int COL_N = 2 * IN_N;
    localparam int PT_N  = PT_OR + 1 + OE_N;
    localparam int SUM_N = 2 * CELL_N;
    localparam int SH_W  = imax(imax(COL_N, PT_OR), SIG_W);

    logic [PT_N-1:0][COL_N-1:0]  prod_cfg;
    logic [SUM_N-1:0][PT_OR-1:0] sum_cfg;
    logic [PT_N-1:0]             pt;
    logic [SUM_N-1:0]            sum;

    pla_cfg_store #(
        .COL_N(COL_N), .PT_N(PT_N), .PT_OR(PT_OR), .SUM_N(SUM_N),
        .SIG_W(SIG_W), .SH_W(SH_W), .ROW_W(ROW_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .sdi(cfg_sdi), .shift_en(cfg_shift),
        .load_en(cfg_load), .read_en(cfg_read), .lock_en(cfg_lock),
        .erase_en(cfg_erase), .plane(cfg_plane), .row(cfg_row),
        .prod_cfg(prod_cfg), .sum_cfg(sum_cfg), .sdo(cfg_sdo)
    );

    pla_prod_plane #(.IN_N(IN_N), .PT_N(PT_N)) u_prod (
        .clk(clk), .rst_n(rst_n), .in_vec(array_in), .cfg(prod_cfg), .pt(pt)
    );

    pla_sum_plane #(.PT_OR(PT_OR), .SUM_N(SUM_N)) u_sum (
        .clk(clk), .rst_n(rst_n), .pt(pt[PT_OR-1:0]), .cfg(sum_cfg), .sum(sum)
    );

    assign sum_d    = sum[CELL_N-1:0];
    assign sum_e    = sum[SUM_N-1:CELL_N];
    assign pt_reset = pt[PT_OR];
    assign pt_oe    = pt[PT_N-1:PT_OR+1];

    // Right after reset the array must show all terms true and all sums low.
    assert_reset_state_R10: assert property (@(posedge clk)
        !$past(rst_n) && rst_n |-> (pt_reset && pt_oe == '1 && sum_d == '0 && sum_e == '0 && !cfg_sdo));

endmodule

// File: tb/test_pla_core.sv
// Bench for pla_core: a behavioural model of the array and configuration
// port, updated on each rising edge and compared at every falling edge.
module test_pla_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [38:0] ain = '0;
    logic        sdi = 1'b0, shift = 1'b0, load = 1'b0, read = 1'b0, lock = 1'b0, erase = 1'b0;
    logic [1:0]  plane = 2'd0;
    logic [6:0]  row = '0;
    logic [17:0] sum_d, sum_e;
    logic        pt_reset, sdo;
    logic [9:0]  pt_oe;

    int checks = 0;
    int fails  = 0;

    bit [77:0] m_prod [75];
    bit [63:0] m_sum  [36];
    bit [71:0] m_sig;
    bit        m_prot;
    bit [77:0] m_sh;

    always #5 clk = ~clk;

    pla_core i_pla_core (
        .clk(clk), .rst_n(rst_n), .array_in(ain), .cfg_sdi(sdi), .cfg_shift(shift),
        .cfg_load(load), .cfg_read(read), .cfg_lock(lock), .cfg_erase(erase),
        .cfg_plane(plane), .cfg_row(row), .sum_d(sum_d), .sum_e(sum_e),
        .pt_reset(pt_reset), .pt_oe(pt_oe), .cfg_sdo(sdo)
    );

    task automatic model_clear();
        foreach (m_prod[i]) m_prod[i] = '0;
        foreach (m_sum[i]) m_sum[i] = '0;
        m_sig = '0; m_prot = 1'b0; m_sh = '0;
    endtask

    // Model of one clock edge, from the requirement text.
    task automatic model_edge();
        bit [77:0] rv;
        if (!rst_n || erase) model_clear();
        else if (lock) m_prot = 1'b1;
        else if (load) begin
            if (plane == 2'd0 && row < 75) m_prod[row] = m_sh;
            else if (plane == 2'd1 && row < 36) m_sum[row] = m_sh[63:0];
            else if (plane == 2'd2) m_sig = m_sh[71:0];
        end else if (read) begin
            rv = '0;
            if (plane == 2'd0 && row < 75 && !m_prot) rv = m_prod[row];
            else if (plane == 2'd1 && row < 36) rv[63:0] = m_sum[row];
            else if (plane == 2'd2) rv[71:0] = m_sig;
            m_sh = rv;
        end else if (shift) m_sh = {sdi, m_sh[77:1]};
    endtask

    function automatic bit model_pt(int p);
        bit v = 1'b1;
        for (int c = 0; c < 78; c++)
            if (m_prod[p][c]) v &= (c % 2 == 0) ? ain[c/2] : ~ain[c/2];
        return v;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        bit [74:0] p;
        bit [35:0] s;
        for (int i = 0; i < 75; i++) p[i] = model_pt(i);
        for (int j = 0; j < 36; j++) s[j] = |(m_sum[j] & p[63:0]);
        chk(tag, "sum_d", 64'(sum_d), 64'(s[17:0]));
        chk(tag, "sum_e", 64'(sum_e), 64'(s[35:18]));
        chk(tag, "pt_reset", 64'(pt_reset), 64'(p[64]));
        chk(tag, "pt_oe", 64'(pt_oe), 64'(p[74:65]));
        chk(tag, "cfg_sdo", 64'(sdo), 64'(m_sh[0]));
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        shift = 0; load = 0; read = 0; lock = 0; erase = 0;
    endtask

    task automatic write_row(logic [1:0] pl, int r, bit [77:0] v, string tag);
        for (int i = 0; i < 78; i++) begin
            sdi = v[i]; shift = 1; step("R5");
        end
        plane = pl; row = 7'(r); load = 1; step(tag);
    endtask

    task automatic read_row(logic [1:0] pl, int r, string tag);
        plane = pl; row = 7'(r); read = 1; step(tag);
        for (int i = 0; i < 78; i++) begin
            sdi = 1'b0; shift = 1; step(tag);
        end
    endtask

    task automatic sweep(int n, string tag);
        for (int k = 0; k < n; k++) begin
            ain = {7'($urandom), $urandom};
            step(tag);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit [77:0] v;
        model_clear();
        @(negedge clk);
        step("R10"); step("R10");
        rst_n = 1'b1;
        step("R10");
        sweep(4, "R10");

        // Product rows: R1 literal selection, R2 empty/contradiction, R3 routing.
        v = '0; v[0] = 1; v[3] = 1; write_row(2'd0, 0, v, "R1");       // in0 & ~in1
        v = '0; v[10] = 1; v[11] = 1; write_row(2'd0, 1, v, "R2");     // in5 & ~in5
        v = '0; v[76] = 1; write_row(2'd0, 63, v, "R1");               // in38
        v = '0; v[20] = 1; write_row(2'd0, 64, v, "R3");               // reset term: in10
        v = '0; v[41] = 1; write_row(2'd0, 65, v, "R3");               // oe0: ~in20
        v = '0; v[74] = 1; v[72] = 1; write_row(2'd0, 74, v, "R3");    // oe9: in37 & in36
        // Sum rows: R4.
        v = '0; v[0] = 1; write_row(2'd1, 0, v, "R4");
        v = '0; v[0] = 1; v[63] = 1; write_row(2'd1, 1, v, "R4");
        v = '0; v[1] = 1; write_row(2'd1, 2, v, "R4");
        v = '0; v[63:0] = '1; write_row(2'd1, 18, v, "R4");
        v = '0; v[2] = 1; write_row(2'd1, 35, v, "R4");
        sweep(40, "R1");
        ain = '0; step("R2");
        ain = '1; step("R2");
        ain = 39'h1; step("R4");

        // Readback and signature: R5, R7.
        read_row(2'd1, 1, "R7");
        read_row(2'd0, 74, "R7");
        v = {6'h15, 72'hA5_0123_4567_89AB_CDEF};
        write_row(2'd2, 0, v, "R6");
        read_row(2'd2, 0, "R7");

        // Ignored loads and blank reads: R6, R7.
        v = '1; write_row(2'd0, 80, v, "R6");
        write_row(2'd1, 40, v, "R6");
        write_row(2'd3, 0, v, "R6");
        sweep(6, "R6");
        read_row(2'd0, 90, "R7");
        read_row(2'd3, 0, "R7");

        // Priority: load beats read, lock beats load, erase beats lock: R11.
        read_row(2'd0, 0, "R11");
        plane = 2'd1; row = 7'd2; load = 1; read = 1; step("R11");
        read_row(2'd1, 2, "R11");
        sdi = 1; shift = 1; read = 1; plane = 2'd2; step("R11");
        sweep(4, "R11");

        // Protection: R8.
        lock = 1; plane = 2'd1; row = 7'd0; load = 1; step("R8");
        read_row(2'd0, 0, "R8");
        read_row(2'd1, 1, "R8");
        read_row(2'd2, 0, "R8");
        v = '0; v[1] = 1; write_row(2'd0, 2, v, "R8");
        sweep(6, "R8");
        read_row(2'd0, 2, "R8");
        // Erase together with lock: erase wins, all clear: R9, R11.
        erase = 1; lock = 1; step("R11");
        sweep(6, "R9");
        read_row(2'd0, 0, "R9");
        v = '0; v[5] = 1; write_row(2'd0, 3, v, "R9");
        read_row(2'd0, 3, "R9");
        lock = 1; step("R8");
        read_row(2'd0, 3, "R8");
        rst_n = 0; step("R10");
        rst_n = 1; step("R10");
        read_row(2'd0, 3, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule